// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block is the digital controller that sits between a host's direction, speed and enable signals and the four gate drivers of a two-leg H-bridge. Each leg (A and B) owns one high-side and one low-side switch. The leg's direction input selects which of its two switches conducts, so the pair of direction inputs gives the four motor modes: clockwise, counter-clockwise, brake to supply and brake to ground. A PWM input chops only the low-side switches, so motor speed is set while the high-side path stays steady.

Each leg has its own enable, sensed from an open-drain line that something outside can pull low. Each leg also has its own fault latch. The latch is set by a high-side overtemperature flag or by a low-side overcurrent flag. While the latch is set, the leg's switches are held off and the line is pulled low to report the fault. The latch clears only on a rising edge of that leg's direction input, after that input has been synchronised. When a leg's direction input changes, both switches of that leg stay off for a programmable number of cycles before the new switch is turned on. An undervoltage flag forces the whole bridge off. The block also gates the current-sense mirror and reports when the bridge is idle.

Top module: `hbridge_ctrl`

## Requirements
- R1: With the leg enabled, no fault latched, no undervoltage and PWM high, a leg whose synchronised direction input is 1 drives only its high-side gate, and a leg whose direction input is 0 drives only its low-side gate. The four modes follow from this: 11 is brake to supply, 10 is clockwise (HS_A and LS_B), 01 is counter-clockwise (HS_B and LS_A) and 00 is brake to ground.
- R2: While PWM is low, both low-side gates are off one cycle later in every mode. The high-side gates are unaffected. When PWM returns high, the low-sides follow the direction inputs again.
- R3: While a leg's sensed enable is low, both gates of that leg are off one cycle later. The other leg is unaffected.
- R4: A high-side overtemperature or a low-side overcurrent flag on a leg sets that leg's fault latch. One cycle later the leg's gates are off and its diagnostic pull-down is high. The other leg keeps operating.
- R5: A fault latch clears only on a rising edge of that leg's synchronised direction input while the fault flag is absent. A falling edge does not clear it, and a rising edge while the flag is still present leaves the latch set.
- R6: A change of a leg's synchronised direction input holds both gates of that leg off for DELAY_CYCLES cycles before the new gate turns on. The new gate shows at the gate output 3 + DELAY_CYCLES cycles after the input change, counting two sync stages. The high-side and low-side of one leg are never on together.
- R7: While the undervoltage flag is high, all four gates are off one cycle later. Normal operation resumes when the flag drops.
- R8: The current-sense enable output is the inverse of the sense-disable input.
- R9: The standby output is high one cycle after both synchronised direction inputs, PWM and both sensed enables are low and no fault latch is set. Otherwise it is low.
- R10: A leg's diagnostic pull-down stays high for as long as its fault latch is set, even while that leg's enable is being held low from outside.
- R11: During reset, all gate outputs, both diagnostic pull-downs and standby are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction input of leg A (asynchronous) |
| dir_b | input | 1 | Direction input of leg B (asynchronous) |
| pwm | input | 1 | Low-side modulation input |
| en_sense_a | input | 1 | Sensed level of leg A's open-drain enable line |
| en_sense_b | input | 1 | Sensed level of leg B's open-drain enable line |
| hot_a | input | 1 | Leg A high-side overtemperature flag |
| ovc_a | input | 1 | Leg A low-side overcurrent flag |
| hot_b | input | 1 | Leg B high-side overtemperature flag |
| ovc_b | input | 1 | Leg B low-side overcurrent flag |
| uv | input | 1 | Supply undervoltage flag |
| sense_off | input | 1 | Current-sense disable |
| hs_a | output | 1 | Leg A high-side gate command |
| ls_a | output | 1 | Leg A low-side gate command |
| hs_b | output | 1 | Leg B high-side gate command |
| ls_b | output | 1 | Leg B low-side gate command |
| diag_pull_a | output | 1 | Pull leg A's enable line low (fault report) |
| diag_pull_b | output | 1 | Pull leg B's enable line low (fault report) |
| sense_en | output | 1 | Current-sense mirror enable |
| standby | output | 1 | Bridge idle indicator |

## Verification
Some properties are checked by the assertions on every cycle. These are: no leg ever has both gates on, a low PWM, a low enable and undervoltage each blank their gates one cycle later, a fault flag raises the pull-down and blanks the leg, and a pull-down only drops after a synchronised rising edge of its direction input. Other behaviour can only be shown by the bench's scenarios. That covers the mode truth table itself, the exact length of the break-before-make gap, a latch that survives a falling edge or a persisting fault, the pull-down held while the enable line is low from outside, and the standby and sense decodes.

// File: rtl/hb_pkg.sv
package hb_pkg;

   localparam int LEGS = 2;

   typedef enum logic [1:0] {
      DRV_FLOAT = 2'd0,
      DRV_HIGH  = 2'd1,
      DRV_LOW   = 2'd2
   } drive_e;

   // Leg drive selection: direction picks the conducting switch when allowed.
   function automatic drive_e pick_drive(input logic allow, input logic dir);
      drive_e d;
      if (!allow)   d = DRV_FLOAT;
      else if (dir) d = DRV_HIGH;
      else          d = DRV_LOW;
      return d;
   endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] chg
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hb_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hb_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
         prev_q <= '0;
      end else begin
         stg[0] <= din;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
         prev_q <= stg[STAGES-1];
      end
   end

   assign lvl  = stg[STAGES-1];
   assign rise = lvl & ~prev_q;
   assign chg  = lvl ^ prev_q;

endmodule

// File: rtl/hb_leg.sv
module hb_leg
   import hb_pkg::*;
#(
   parameter int DELAY_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_lvl,
   input  logic dir_rise,
   input  logic dir_chg,
   input  logic pwm,
   input  logic en,
   input  logic uv,
   input  logic flt_hot,
   input  logic flt_ovc,
   output logic hs,
   output logic ls,
   output logic latched
);

   localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYCLES);

   if (DELAY_CYCLES < 1) begin : g_bad_delay
      $error("hb_leg: DELAY_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             latch_q, latch_nxt;
   logic             allow;
   drive_e           drv;
   logic             hs_q, ls_q;

   // Break-before-make window counter
   always_comb begin
      if (dir_chg)            cnt_nxt = CNT_LOAD;
      else if (cnt_q != '0)   cnt_nxt = cnt_q - 1'b1;
      else                    cnt_nxt = cnt_q;
   end

   // Fault latch: set by any flag, cleared only by a direction rising edge
   assign latch_nxt = flt_hot | flt_ovc | (latch_q & ~dir_rise);

   assign allow = en & ~uv & ~latch_nxt & (cnt_nxt == '0);
   assign drv   = pick_drive(allow, dir_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         latch_q <= 1'b0;
         hs_q    <= 1'b0;
         ls_q    <= 1'b0;
      end else begin
         cnt_q   <= cnt_nxt;
         latch_q <= latch_nxt;
         hs_q    <= (drv == DRV_HIGH);
         ls_q    <= (drv == DRV_LOW) & pwm;
      end
   end

   assign hs      = hs_q;
   assign ls      = ls_q;
   assign latched = latch_q;

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
   import hb_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int DELAY_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_a,
   input  logic dir_b,
   input  logic pwm,
   input  logic en_sense_a,
   input  logic en_sense_b,
   input  logic hot_a,
   input  logic ovc_a,
   input  logic hot_b,
   input  logic ovc_b,
   input  logic uv,
   input  logic sense_off,
   output logic hs_a,
   output logic ls_a,
   output logic hs_b,
   output logic ls_b,
   output logic diag_pull_a,
   output logic diag_pull_b,
   output logic sense_en,
   output logic standby
);

   logic [LEGS-1:0] dir_raw, dir_lvl, dir_rise, dir_chg;
   logic [LEGS-1:0] en_v, hot_v, ovc_v;
   logic [LEGS-1:0] hs_v, ls_v, latch_v;
   logic            standby_q;

   assign dir_raw = {dir_b, dir_a};
   assign en_v    = {en_sense_b, en_sense_a};
   assign hot_v   = {hot_b, hot_a};
   assign ovc_v   = {ovc_b, ovc_a};

   hb_sync #(
      .STAGES(SYNC_STAGES),
      .WIDTH (LEGS)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (dir_raw),
      .lvl  (dir_lvl),
      .rise (dir_rise),
      .chg  (dir_chg)
   );

   for (genvar g = 0; g < LEGS; g++) begin : g_leg
      hb_leg #(
         .DELAY_CYCLES(DELAY_CYCLES)
      ) u_leg (
         .clk     (clk),
         .rst_n   (rst_n),
         .dir_lvl (dir_lvl[g]),
         .dir_rise(dir_rise[g]),
         .dir_chg (dir_chg[g]),
         .pwm     (pwm),
         .en      (en_v[g]),
         .uv      (uv),
         .flt_hot (hot_v[g]),
         .flt_ovc (ovc_v[g]),
         .hs      (hs_v[g]),
         .ls      (ls_v[g]),
         .latched (latch_v[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) standby_q <= 1'b0;
      else        standby_q <= ~|{dir_lvl, pwm, en_v, latch_v};
   end

   assign hs_a        = hs_v[0];
   assign ls_a        = ls_v[0];
   assign hs_b        = hs_v[1];
   assign ls_b        = ls_v[1];
   assign diag_pull_a = latch_v[0];
   assign diag_pull_b = latch_v[1];
   assign sense_en    = ~sense_off;
   assign standby     = standby_q;

endmodule

// File: rtl/hb_chk.sv
module hb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pwm,
   input logic       en_sense_a,
   input logic       en_sense_b,
   input logic       hot_a,
   input logic       ovc_a,
   input logic       hot_b,
   input logic       ovc_b,
   input logic       uv,
   input logic       hs_a,
   input logic       ls_a,
   input logic       hs_b,
   input logic       ls_b,
   input logic       diag_pull_a,
   input logic       diag_pull_b,
   input logic [1:0] dir_rise
);

   // R6
   no_shoot_a_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hs_a && ls_a));
   // R6
   no_shoot_b_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hs_b && ls_b));
   // R6
   bbm_a_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls_a) |-> $past(!hs_a));
   // R6
   bbm_b_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_b) |-> $past(!ls_b));
   // R2
   pwm_blank_chk: assert property (@(posedge clk) disable iff (!rst_n) !pwm |=> (!ls_a && !ls_b));
   // R3
   en_off_a_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_sense_a |=> (!hs_a && !ls_a));
   // R3
   en_off_b_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_sense_b |=> (!hs_b && !ls_b));
   // R7
   uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv |=> (!hs_a && !ls_a && !hs_b && !ls_b));
   // R4
   fault_set_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_a || ovc_a) |=> (diag_pull_a && !hs_a && !ls_a));
   // R4
   fault_set_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_b || ovc_b) |=> (diag_pull_b && !hs_b && !ls_b));
   // R5
   clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(diag_pull_a) |-> $past(dir_rise[0]));
   // R5
   clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(diag_pull_b) |-> $past(dir_rise[1]));

endmodule

bind hbridge_ctrl hb_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwm        (pwm),
   .en_sense_a (en_sense_a),
   .en_sense_b (en_sense_b),
   .hot_a      (hot_a),
   .ovc_a      (ovc_a),
   .hot_b      (hot_b),
   .ovc_b      (ovc_b),
   .uv         (uv),
   .hs_a       (hs_a),
   .ls_a       (ls_a),
   .hs_b       (hs_b),
   .ls_b       (ls_b),
   .diag_pull_a(diag_pull_a),
   .diag_pull_b(diag_pull_b),
   .dir_rise   (dir_rise)
);

// File: tb/sim_hbridge_ctrl.sv
module sim_hbridge_ctrl;

   localparam int DLY = 8;
   localparam int SETTLE = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_a = 0, dir_b = 0, pwm = 0, en_sense_a = 0, en_sense_b = 0;
   logic hot_a = 0, ovc_a = 0, hot_b = 0, ovc_b = 0, uv = 0, sense_off = 0;
   logic hs_a, ls_a, hs_b, ls_b, diag_pull_a, diag_pull_b, sense_en, standby;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   hbridge_ctrl #(.SYNC_STAGES(2), .DELAY_CYCLES(DLY)) u0 (.*);

   // vector: {dir_a,dir_b,pwm,en_a,en_b,uv,sense_off, hs_a,ls_a,hs_b,ls_b,sense_en}
   localparam int NV = 10;
   localparam logic [11:0] VEC [NV] = '{
      12'b1_1_1_1_1_0_0_1_0_1_0_1, // R1 brake to supply
      12'b1_0_1_1_1_0_0_1_0_0_1_1, // R1 clockwise
      12'b0_1_1_1_1_0_0_0_1_1_0_1, // R1 counter-clockwise
      12'b0_0_1_1_1_0_1_0_1_0_1_0, // R1 brake to ground, R8 sense disabled
      12'b0_0_0_1_1_0_0_0_0_0_0_1, // R2 PWM low blanks low-sides
      12'b1_0_0_1_1_0_0_1_0_0_0_1, // R2 high-side unaffected by PWM
      12'b1_0_1_0_1_0_0_0_0_0_1_1, // R3 leg A disabled
      12'b0_1_1_1_0_0_0_0_1_0_0_1, // R3 leg B disabled
      12'b1_0_1_1_1_1_0_0_0_0_0_1, // R7 undervoltage
      12'b1_0_1_1_1_0_0_1_0_0_1_1  // R7 resume
   };
   localparam int VREQ [NV] = '{1, 1, 1, 1, 2, 2, 3, 3, 7, 7};

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      cyc(3);
      // R11 reset state
      chk("R11", "gates/diag/standby in reset",
          {1'b0, hs_a, ls_a, hs_b, ls_b, diag_pull_a, diag_pull_b, standby}, 8'h00);
      rst_n = 1'b1;
      cyc(SETTLE);
      // R9 idle after reset
      chk("R9", "standby idle", {7'd0, standby}, 8'h01);

      for (int i = 0; i < NV; i++) begin
         {dir_a, dir_b, pwm, en_sense_a, en_sense_b, uv, sense_off} = VEC[i][11:5];
         cyc(SETTLE);
         chk($sformatf("R%0d", VREQ[i]), $sformatf("vector %0d gates", i),
             {4'd0, hs_a, ls_a, hs_b, ls_b}, {4'd0, VEC[i][4:1]});
         chk($sformatf("R%0d", VREQ[i]), $sformatf("vector %0d sense", i),
             {7'd0, sense_en}, {7'd0, VEC[i][0]});
      end

      // R9 not standby while active
      chk("R9", "standby while active", {7'd0, standby}, 8'h00);

      // R4 fault on leg A, leg B keeps going (state: CW)
      hot_a = 1'b1;
      cyc(1);
      hot_a = 1'b0;
      cyc(3);
      chk("R4", "leg A after fault {hs_a,ls_a,diag_a}", {5'd0, hs_a, ls_a, diag_pull_a}, 8'h01);
      chk("R4", "leg B unaffected {hs_b,ls_b}", {6'd0, hs_b, ls_b}, 8'h01);

      // R5 falling edge does not clear
      dir_a = 1'b0;
      cyc(SETTLE);
      chk("R5", "falling edge keeps latch {hs_a,ls_a,diag_a}", {5'd0, hs_a, ls_a, diag_pull_a}, 8'h01);
      // R5 rising edge clears
      dir_a = 1'b1;
      cyc(SETTLE);
      chk("R5", "rising edge clears {hs_a,ls_a,diag_a}", {5'd0, hs_a, ls_a, diag_pull_a}, 8'h04);

      // R10 diag held while enable pulled low externally
      ovc_a = 1'b1;
      cyc(1);
      ovc_a = 1'b0;
      en_sense_a = 1'b0;
      cyc(5);
      chk("R10", "diag_a with enable low", {7'd0, diag_pull_a}, 8'h01);
      en_sense_a = 1'b1;
      cyc(5);
      chk("R10", "diag_a after enable back", {6'd0, hs_a, diag_pull_a}, 8'h01);
      dir_a = 1'b0;
      cyc(SETTLE);
      dir_a = 1'b1;
      cyc(SETTLE);
      chk("R10", "leg A recovered {hs_a,diag_a}", {6'd0, hs_a, diag_pull_a}, 8'h02);

      // R5 persisting fault survives a rising edge
      ovc_b = 1'b1;
      dir_b = 1'b1;
      cyc(SETTLE);
      chk("R5", "persisting fault {hs_b,ls_b,diag_b}", {5'd0, hs_b, ls_b, diag_pull_b}, 8'h01);
      ovc_b = 1'b0;
      cyc(5);
      chk("R5", "latch after flag drops", {7'd0, diag_pull_b}, 8'h01);
      dir_b = 1'b0;
      cyc(SETTLE);
      dir_b = 1'b1;
      cyc(SETTLE);
      chk("R5", "leg B cleared {hs_b,ls_b,diag_b}", {5'd0, hs_b, ls_b, diag_pull_b}, 8'h04);

      // R6 break-before-make timing on leg A (HS -> LS)
      dir_a = 1'b0;
      for (int n = 1; n <= DLY + 6; n++) begin
         cyc(1);
         chk("R6", $sformatf("cycle %0d {hs_a,ls_a}", n), {6'd0, hs_a, ls_a},
             {6'd0, (n <= 2) ? 1'b1 : 1'b0, (n >= DLY + 3) ? 1'b1 : 1'b0});
      end

      // R9 standby entry and exit
      {dir_a, dir_b, pwm, en_sense_a, en_sense_b} = 5'b0;
      cyc(SETTLE);
      chk("R9", "standby all low", {7'd0, standby}, 8'h01);
      en_sense_a = 1'b1;
      cyc(3);
      chk("R9", "standby with enable high", {7'd0, standby}, 8'h00);
      en_sense_a = 1'b0;
      hot_b = 1'b1;
      cyc(1);
      hot_b = 1'b0;
      cyc(3);
      chk("R9", "standby blocked by latched fault", {7'd0, standby}, 8'h00);

      // R11 reset mid-run
      {dir_a, dir_b, pwm, en_sense_a, en_sense_b} = 5'b11111;
      cyc(SETTLE);
      rst_n = 1'b0;
      cyc(1);
      chk("R11", "reset asserted mid-run",
          {1'b0, hs_a, ls_a, hs_b, ls_b, diag_pull_a, diag_pull_b, standby}, 8'h00);

      finish_run();
   end

endmodule